// File: doc/BRIEF.md
# Legacy Boot ROM Alias Decoder

This block sorts every memory request of a PC-style address map into one of three outcomes: system DRAM, the boot ROM, or a write that is thrown away. The ROM image sits at the very top of the physical space, so the fetch at 0xFFFFFFF0 after reset lands inside it. The last 128 KiB of the same image is also decoded in the legacy window 0x000E0000–0x000FFFFF. Code that has reloaded its segment with a far jump therefore keeps running out of the ROM.

The legacy window is cut into eight 16 KiB segments. Each segment has a two-bit attribute that steers reads and writes separately. Firmware can first leave reads on the ROM while writes fall through to DRAM, which lets it copy the ROM into RAM. It then flips reads over to DRAM and runs from the shadow copy. A strap input narrows the bus to 24 bits. In that mode the top eight address bits are ignored and the top ROM window ends at 0x00FFFFFF.

Decode results are registered, one cycle after the request. For ROM hits the decoder also returns the byte offset into the ROM image.

Top module: `bios_alias_decoder`

## Requirements
- R1: After reset all outputs are low and every segment attribute is 2'b00, so reads of 0xE0000–0xFFFFF go to the ROM and writes there are dropped.
- R2: With the full bus, a read of an address from (2^32 − ROM size) up to 0xFFFFFFFF asserts rom_sel with rom_offset equal to the address minus that base. For the default 1 MiB image, 0xFFFFFFF0 gives offset 0xFFFF0.
- R3: A read in 0xE0000–0xFFFFF whose segment attribute bit0 is 0 asserts rom_sel with rom_offset = address − 0xE0000 + ROM size − 0x20000.
- R4: A read in the legacy window whose segment attribute bit0 is 1 asserts dram_sel, and rom_offset is 0.
- R5: A write in the legacy window whose segment attribute bit1 is 1 asserts dram_sel. Any other write that decodes to the ROM, in either window, asserts wr_drop with both selects low.
- R6: Segment k (0..7) covers 0xE0000 + k·0x4000 up to 16 KiB above that. A configuration write with cfg_we=1 loads cfg_attr into segment cfg_seg and leaves the other segments unchanged.
- R7: With bus24=1, address bits 31:24 are ignored and the top ROM window spans (2^24 − ROM size) to 0xFFFFFF. With bus24=0, 0x00FFFFF0 is DRAM.
- R8: Every valid request outside both ROM windows asserts dram_sel with rom_offset 0.
- R9: Outputs reflect the request sampled at the previous rising clock edge. A cycle with req_valid=0 yields all outputs low.
- R10: For each valid request exactly one of dram_sel, rom_sel and wr_drop is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Physical request address |
| req_write | input | 1 | 1 = write, 0 = read |
| bus24 | input | 1 | Strap: 1 = 24-bit physical bus |
| cfg_we | input | 1 | Load one segment attribute |
| cfg_seg | input | 3 | Segment index to load |
| cfg_attr | input | 2 | Attribute: bit0 reads to DRAM, bit1 writes to DRAM |
| dram_sel | output | 1 | Request targets DRAM |
| rom_sel | output | 1 | Request reads the ROM |
| wr_drop | output | 1 | Write to ROM discarded |
| rom_offset | output | 20 | Byte offset in the ROM image |

## Verification
Directed vectors probe both edges of each window: the reset fetch address, the first and last ROM bytes, and the addresses one below and one above the legacy range. These show whether the window comparisons are off by one. Each of the four attribute codes is then loaded into one segment, and its neighbour is probed to show that read and write steering are separate and confined to that segment. The 24-bit strap is tried with garbage in the upper address bits and against the same address on the full bus, which tells masking apart from aliasing. Random traffic, weighted toward the windows and mixed with random attribute loads, is compared against a bench model.

// File: rtl/bios_dec_pkg.sv
`timescale 1ns/1ps
package bios_dec_pkg;
  // Legacy window fixed by the PC memory map
  localparam logic [31:0] LEGACY_BASE = 32'h000E_0000;
  localparam int unsigned LEGACY_LOG2 = 17;  // 128 KiB
  localparam int unsigned NARROW_W = 24;

  typedef struct packed {
    logic dram;
    logic rom;
    logic drop;
  } route_t;
endpackage

// File: rtl/seg_attr_bank.sv
`timescale 1ns/1ps
module seg_attr_bank #(
  parameter int unsigned NSEG  = 8,
  localparam int unsigned SEG_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEG_W-1:0] idx,
  input  logic [1:0]       attr_in,
  output logic [1:0]       attrs [NSEG]
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          attrs[g] <= 2'b00;
      else if (we && idx == SEG_W'(g))     attrs[g] <= attr_in;
    end
  end
endmodule

// File: rtl/addr_classify.sv
`timescale 1ns/1ps
module addr_classify
  import bios_dec_pkg::*;
#(
  parameter int unsigned ROM_LOG2 = 20,
  parameter int unsigned SEG_LOG2 = 14,
  localparam int unsigned SEG_W = LEGACY_LOG2 - SEG_LOG2
) (
  input  logic [31:0]         addr,
  input  logic                bus24,
  output logic                in_top,
  output logic                in_low,
  output logic [SEG_W-1:0]    seg_idx,
  output logic [ROM_LOG2-1:0] ea_lo
);
  localparam logic [32:0] ROM_SZ = 33'd1 << ROM_LOG2;
  localparam logic [32:0] BASE_FULL_W = 33'h1_0000_0000 - ROM_SZ;
  localparam logic [32:0] BASE_NARROW_W = (33'd1 << NARROW_W) - ROM_SZ;
  localparam logic [31:0] BASE_FULL = BASE_FULL_W[31:0];
  localparam logic [31:0] BASE_NARROW = BASE_NARROW_W[31:0];

  // Effective address: the narrow bus leaves the top byte undriven
  function automatic logic [31:0] eff_addr(input logic [31:0] a, input logic narrow);
    return narrow ? {8'h00, a[NARROW_W-1:0]} : a;
  endfunction

  logic [31:0] ea;
  always_comb begin
    ea      = eff_addr(addr, bus24);
    in_top  = ea >= (bus24 ? BASE_NARROW : BASE_FULL);
    in_low  = ea[31:LEGACY_LOG2] == LEGACY_BASE[31:LEGACY_LOG2];
    seg_idx = ea[LEGACY_LOG2-1:SEG_LOG2];
    ea_lo   = ea[ROM_LOG2-1:0];
  end
endmodule

// File: rtl/route_stage.sv
`timescale 1ns/1ps
module route_stage
  import bios_dec_pkg::*;
#(
  parameter int unsigned ROM_LOG2 = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                in_top,
  input  logic                in_low,
  input  logic [1:0]          seg_attr,
  input  logic [ROM_LOG2-1:0] ea_lo,
  output route_t              route_q,
  output logic [ROM_LOG2-1:0] offset_q
);
  localparam logic [32:0] LOW_BIAS_W =
    (33'd1 << ROM_LOG2) - (33'd1 << LEGACY_LOG2) - {1'b0, LEGACY_BASE};
  localparam logic [ROM_LOG2-1:0] LOW_BIAS = LOW_BIAS_W[ROM_LOG2-1:0];

  // Top window base is ROM-size aligned: offset is the low address bits
  function automatic logic [ROM_LOG2-1:0] top_off(input logic [ROM_LOG2-1:0] a);
    return a;
  endfunction

  // Low alias shows the last 128 KiB of the image
  function automatic logic [ROM_LOG2-1:0] low_off(input logic [ROM_LOG2-1:0] a);
    return a + LOW_BIAS;
  endfunction

  route_t              route_d;
  logic [ROM_LOG2-1:0] offset_d;

  always_comb begin
    route_d  = '0;
    offset_d = '0;
    if (req_valid) begin
      if (in_top) begin
        if (req_write) route_d.drop = 1'b1;
        else begin
          route_d.rom = 1'b1;
          offset_d    = top_off(ea_lo);
        end
      end else if (in_low) begin
        if (req_write) begin
          if (seg_attr[1]) route_d.dram = 1'b1;
          else             route_d.drop = 1'b1;
        end else if (seg_attr[0]) begin
          route_d.dram = 1'b1;
        end else begin
          route_d.rom = 1'b1;
          offset_d    = low_off(ea_lo);
        end
      end else begin
        route_d.dram = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q  <= '0;
      offset_q <= '0;
    end else begin
      route_q  <= route_d;
      offset_q <= offset_d;
    end
  end
endmodule

// File: rtl/bios_alias_decoder.sv
`timescale 1ns/1ps
module bios_alias_decoder
  import bios_dec_pkg::*;
#(
  parameter int unsigned ROM_LOG2 = 20,
  parameter int unsigned SEG_LOG2 = 14,
  localparam int unsigned SEG_W = LEGACY_LOG2 - SEG_LOG2,
  localparam int unsigned NSEG  = 1 << SEG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [31:0]         req_addr,
  input  logic                req_write,
  input  logic                bus24,
  input  logic                cfg_we,
  input  logic [SEG_W-1:0]    cfg_seg,
  input  logic [1:0]          cfg_attr,
  output logic                dram_sel,
  output logic                rom_sel,
  output logic                wr_drop,
  output logic [ROM_LOG2-1:0] rom_offset
);
  logic [1:0]          attrs [NSEG];
  logic                in_top;
  logic                in_low;
  logic [SEG_W-1:0]    seg_idx;
  logic [ROM_LOG2-1:0] ea_lo;
  logic [1:0]          seg_attr;
  route_t              route_q;

  seg_attr_bank #(.NSEG(NSEG)) u_attr (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_seg),
    .attr_in(cfg_attr), .attrs(attrs)
  );

  addr_classify #(.ROM_LOG2(ROM_LOG2), .SEG_LOG2(SEG_LOG2)) u_cls (
    .addr(req_addr), .bus24(bus24), .in_top(in_top), .in_low(in_low),
    .seg_idx(seg_idx), .ea_lo(ea_lo)
  );

  assign seg_attr = attrs[seg_idx];

  route_stage #(.ROM_LOG2(ROM_LOG2)) u_route (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .in_top(in_top), .in_low(in_low), .seg_attr(seg_attr), .ea_lo(ea_lo),
    .route_q(route_q), .offset_q(rom_offset)
  );

  assign dram_sel = route_q.dram;
  assign rom_sel  = route_q.rom;
  assign wr_drop  = route_q.drop;
endmodule

// File: rtl/bios_alias_decoder_chk.sv
`timescale 1ns/1ps
module bios_alias_decoder_chk #(
  parameter int unsigned ROM_LOG2 = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [31:0]         req_addr,
  input logic                req_write,
  input logic                bus24,
  input logic                in_top,
  input logic                dram_sel,
  input logic                rom_sel,
  input logic                wr_drop,
  input logic [ROM_LOG2-1:0] rom_offset
);
  localparam logic [ROM_LOG2-1:0] RV_OFF = {{(ROM_LOG2-4){1'b1}}, 4'h0};

  // R10: one outcome per valid request
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({dram_sel, rom_sel, wr_drop}) == 1);

  // R9: idle cycle leaves every output low
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dram_sel && !rom_sel && !wr_drop && rom_offset == '0);

  // R5: a write never selects the ROM
  p_no_rom_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rom_sel);

  // R2: reset fetch address hits the ROM tail
  p_reset_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !bus24 && req_addr == 32'hFFFF_FFF0
    |=> rom_sel && rom_offset == RV_OFF);

  // R2: the top window never reaches DRAM
  p_top_not_dram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_top |=> !dram_sel);

  // R8: plain low memory below the legacy window is DRAM
  p_low_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr[31:20] == 12'h000 && req_addr[19:17] != 3'b111
    |=> dram_sel && rom_offset == '0);
endmodule

bind bios_alias_decoder bios_alias_decoder_chk #(.ROM_LOG2(ROM_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .bus24(bus24), .in_top(in_top),
  .dram_sel(dram_sel), .rom_sel(rom_sel), .wr_drop(wr_drop),
  .rom_offset(rom_offset)
);

// File: tb/test_bios_alias_decoder.sv
`timescale 1ns/1ps
module test_bios_alias_decoder;
  localparam int unsigned RL = 20;
  localparam longint ROMSZ = 64'd1 << RL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          req_write = 1'b0;
  logic          bus24 = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_seg = '0;
  logic [1:0]    cfg_attr = '0;
  logic          dram_sel, rom_sel, wr_drop;
  logic [RL-1:0] rom_offset;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] shadow [8];

  always #4 clk = ~clk;

  bios_alias_decoder i_bios_alias_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .bus24(bus24), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_attr(cfg_attr), .dram_sel(dram_sel), .rom_sel(rom_sel),
    .wr_drop(wr_drop), .rom_offset(rom_offset)
  );

  // Expected {dram, rom, drop, offset} from the requirements
  function automatic logic [RL+2:0] model(input logic [31:0] a, input logic w, input logic b);
    longint ea, lo, off;
    int seg;
    logic d, r, x;
    ea = b ? longint'(a % 32'h0100_0000) : longint'(a);
    lo = (b ? 64'h100_0000 : 64'h1_0000_0000) - ROMSZ;
    d = 0; r = 0; x = 0; off = 0;
    if (ea >= lo) begin
      if (w) x = 1; else begin r = 1; off = ea - lo; end
    end else if (ea >= 64'hE0000 && ea <= 64'hFFFFF) begin
      seg = int'((ea - 64'hE0000) / 16384);
      if (w) begin
        if (shadow[seg][1]) d = 1; else x = 1;
      end else if (shadow[seg][0]) d = 1;
      else begin r = 1; off = ea - 64'hE0000 + ROMSZ - 64'h20000; end
    end else d = 1;
    return {d, r, x, off[RL-1:0]};
  endfunction

  task automatic compare(input logic [RL+2:0] exp, input string tag);
    logic [RL+2:0] act;
    act = {dram_sel, rom_sel, wr_drop, rom_offset};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got dram=%b rom=%b drop=%b off=%h, expected dram=%b rom=%b drop=%b off=%h",
               tag, act[RL+2], act[RL+1], act[RL], act[RL-1:0],
               exp[RL+2], exp[RL+1], exp[RL], exp[RL-1:0]);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after capture
  task automatic access(input logic [31:0] a, input logic w, input logic b, input string tag);
    logic [RL+2:0] exp;
    req_valid = 1'b1; req_addr = a; req_write = w; bus24 = b;
    exp = model(a, w, b);
    @(posedge clk); @(negedge clk);
    compare(exp, tag);
    req_valid = 1'b0;
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0; req_addr = $urandom; req_write = 1'($urandom);
    @(posedge clk); @(negedge clk);
    compare('0, tag);
  endtask

  task automatic set_attr(input int s, input logic [1:0] v);
    cfg_we = 1'b1; cfg_seg = 3'(s); cfg_attr = v;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    shadow[s] = v;
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom % 5)
      0: return 32'hFFF0_0000 | ($urandom % 32'h0010_0000);
      1: return 32'h000E_0000 | ($urandom % 32'h0002_0000);
      2: return 32'h000D_FFF0 + ($urandom % 32'h40);
      3: return {8'($urandom), 24'hF0_0000 | 24'($urandom % 32'h10_0000)};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd5150);
    for (int i = 0; i < 8; i++) shadow[i] = 2'b00;
    repeat (3) @(negedge clk);
    compare('0, "R1 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare('0, "R1 outputs after reset");
    access(32'h000F_8000, 1'b0, 1'b0, "R1 legacy read after reset");
    access(32'h000E_4000, 1'b1, 1'b0, "R1 legacy write after reset");

    access(32'hFFFF_FFF0, 1'b0, 1'b0, "R2 reset fetch");
    access(32'hFFF0_0000, 1'b0, 1'b0, "R2 first ROM byte");
    access(32'hFFFF_FFFF, 1'b0, 1'b0, "R2 last ROM byte");
    access(32'hFFEF_FFFF, 1'b0, 1'b0, "R8 below top window");
    access(32'h000E_0000, 1'b0, 1'b0, "R3 low alias start");
    access(32'h000F_FFFF, 1'b0, 1'b0, "R3 low alias end");
    access(32'h000D_FFFF, 1'b0, 1'b0, "R8 below legacy window");
    access(32'h0010_0000, 1'b0, 1'b0, "R8 above legacy window");
    access(32'hFFFF_0000, 1'b1, 1'b0, "R5 top window write dropped");
    idle("R9 idle cycle");

    set_attr(4, 2'b10);
    access(32'h000F_0010, 1'b0, 1'b0, "R5 shadow copy read stays ROM");
    access(32'h000F_0010, 1'b1, 1'b0, "R5 shadow copy write to DRAM");
    access(32'h000E_FFFF, 1'b1, 1'b0, "R6 neighbour write still dropped");
    set_attr(4, 2'b01);
    access(32'h000F_3FFF, 1'b0, 1'b0, "R4 read from shadow DRAM");
    access(32'h000F_3FFF, 1'b1, 1'b0, "R5 write protected shadow");
    access(32'h000F_4000, 1'b0, 1'b0, "R6 next segment still ROM");
    set_attr(7, 2'b11);
    access(32'h000F_FFF0, 1'b0, 1'b0, "R4 seg7 read DRAM");
    access(32'h000F_FFF0, 1'b1, 1'b0, "R5 seg7 write DRAM");

    access(32'h00FF_FFF0, 1'b0, 1'b1, "R7 narrow reset fetch");
    access(32'hABFF_FFF0, 1'b0, 1'b1, "R7 narrow ignores top byte");
    access(32'h00EF_FFFF, 1'b0, 1'b1, "R7 narrow below window");
    access(32'h00FF_FFF0, 1'b0, 1'b0, "R7 full bus sees DRAM");
    access(32'h120F_0000, 1'b0, 1'b1, "R7 narrow low alias");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) set_attr(int'($urandom % 8), 2'($urandom));
      if ($urandom % 10 == 0) idle("R9 random idle");
      else access(pick_addr(), 1'($urandom), 1'($urandom % 4 == 0), "R10 random traffic");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule